// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers interrupt events from a bank of peripheral request lines and from five system exception lines, and turns them into one interrupt line and one vector index for a processor core. A rising edge on any request line sets that source's pending bit. The bit stays set until the core acknowledges the vector, or until software writes a 0 to it. Each peripheral source carries its own enable and a programmable priority level from 1 to 3. A global enable gates all peripheral sources and the watchdog timeout. The other four system exceptions bypass every mask.

The winner comes from a tiered choice. Unmasked exceptions come first, then level 3 peripherals, then level 2, then level 1. Inside each tier the source with the lower index wins. The chosen vector is latched and held while the interrupt line is high. On acknowledge, the controller clears the served pending bit. In the same edge it moves straight to the next eligible winner, so the interrupt line does not drop between back-to-back services.

Software reaches the block through a small register port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `irqc_top`

## Requirements
- R1: Among enabled, globally enabled peripheral requests, any level 3 source beats any level 2 source, and level 2 beats level 1. Each source's 2-bit level code takes its low bit from register 3 and its high bit from register 4, at the source's bit position. Codes 0 and 1 mean level 1, code 2 means level 2 and code 3 means level 3.
- R2: Within one level, the peripheral with the lower index wins. Peripheral i is reported as vector 5+i.
- R3: A rising edge on a request input sets its pending bit. Peripheral pending bits read at address 0, bit i. Exception pending bits read at address 1: bit 0 primary oscillator failure, bit 1 watchdog oscillator failure, bit 2 illegal instruction, bit 3 trap, bit 4 watchdog timeout. An input held high does not set the bit again once it has been cleared.
- R4: An acknowledge while the interrupt output is high clears the pending bit of the presented vector and no other. An acknowledge while the output is low changes nothing.
- R5: A write to address 0 or 1 clears each pending bit written as 0 and leaves each bit written as 1 unchanged.
- R6: A source whose enable bit (address 2, bit i) is 0, or any peripheral while the global enable is 0, still latches its pending bit but does not raise the interrupt output.
- R7: Exceptions at bits 0 to 3 raise the interrupt whatever the enables hold. Their vectors are 0 to 3. They outrank every peripheral, and the lower bit wins among them.
- R8: The watchdog timeout (vector 4) is eligible only when both the global enable (address 5, bit 0) and the watchdog enable (address 5, bit 1) are 1.
- R9: When a request edge and a write of 0 hit the same pending bit in one cycle, the bit ends up set.
- R10: The interrupt output rises on the second clock edge after a request edge. While the output stays high and no acknowledge comes, the vector holds even if a higher-priority request arrives. After an acknowledge, the output stays high with the next winner's vector when another eligible request remains.
- R11: After reset the interrupt output is low and registers 0 to 5 all read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register select for reads and writes |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | REG_W | Write data |
| regRdData | output | REG_W | Read data for regAddr |
| periphReq | input | NUM_PERIPH | Peripheral request lines, rising-edge sensitive |
| excReq | input | 5 | System exception request lines, rising-edge sensitive |
| ackIn | input | 1 | Core acknowledges the presented vector |
| irqOut | output | 1 | Interrupt request to the core |
| vecOut | output | VEC_W | Index of the presented vector |

## Verification
On every cycle, the assertions check that the tiered winner is correct: an unmasked exception is chosen over every peripheral, a level 3 candidate is never passed over, and a pending nonmaskable exception always yields a winner. They also check that a request edge always lands in its pending bit, that an acknowledge clears the served bit, and that the vector holds while the interrupt line is high and no acknowledge comes. Only the directed scenarios can show the register encodings, the write-1-has-no-effect rule, the order of vectors across a chain of acknowledges, the two-edge latency, and the gating of the watchdog by both enables.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned NUM_EXC = 5;

  // exception bit positions, also their vector numbers and their order
  localparam int unsigned EXC_OSC_MAIN   = 0;
  localparam int unsigned EXC_OSC_WDOG   = 1;
  localparam int unsigned EXC_BAD_OPCODE = 2;
  localparam int unsigned EXC_TRAP       = 3;
  localparam int unsigned EXC_WDOG_TMO   = 4;

  typedef enum logic [2:0] {
    ADDR_PEND_P = 3'd0,
    ADDR_PEND_E = 3'd1,
    ADDR_ENABLE = 3'd2,
    ADDR_LVL_LO = 3'd3,
    ADDR_LVL_HI = 3'd4,
    ADDR_CTRL   = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic pendPClr;
    logic pendEClr;
    logic enWr;
    logic lvlLoWr;
    logic lvlHiWr;
    logic ctlWr;
    logic ack;
  } ctlStb_t;

  function automatic logic [1:0] levelOf(logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction

endpackage

// File: rtl/irqc_find_first.sv
module irqc_find_first #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned NUM_SRC    = NUM_PERIPH + NUM_EXC,
  parameter int unsigned VEC_W      = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStb_t               stb,
  input  logic [REG_W-1:0]      wrData,
  input  logic [2:0]            regAddr,
  input  logic [VEC_W-1:0]      ackIdx,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_EXC-1:0]    excReq,
  output logic [REG_W-1:0]      rdData,
  output logic [NUM_SRC-1:0]    eligible,
  output logic                  winFound,
  output logic [VEC_W-1:0]      winIdx
);

  localparam int unsigned PIDX_W = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1;
  localparam int unsigned EIDX_W = $clog2(NUM_EXC);

  logic [NUM_SRC-1:0]    prevReq, pend, setMask, clrMask, ackMask, cand;
  logic [NUM_PERIPH-1:0] enable, lvlLo, lvlHi;
  logic                  globEn, wdogEn;

  // edge capture: each source sets its bit once per rising edge
  assign setMask = {periphReq, excReq} & ~prevReq;
  assign ackMask = stb.ack ? (NUM_SRC'(1) << ackIdx) : '0;

  always_comb begin
    clrMask = '0;
    if (stb.pendEClr) clrMask[NUM_EXC-1:0]       = ~wrData[NUM_EXC-1:0];
    if (stb.pendPClr) clrMask[NUM_SRC-1:NUM_EXC] = ~wrData[NUM_PERIPH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevReq <= '0;
      pend    <= '0;
      enable  <= '0;
      lvlLo   <= '0;
      lvlHi   <= '0;
      globEn  <= 1'b0;
      wdogEn  <= 1'b0;
    end else begin
      prevReq <= {periphReq, excReq};
      pend    <= (pend & ~clrMask & ~ackMask) | setMask;  // set has precedence
      if (stb.enWr)    enable <= wrData[NUM_PERIPH-1:0];
      if (stb.lvlLoWr) lvlLo  <= wrData[NUM_PERIPH-1:0];
      if (stb.lvlHiWr) lvlHi  <= wrData[NUM_PERIPH-1:0];
      if (stb.ctlWr) begin
        globEn <= wrData[0];
        wdogEn <= wrData[1];
      end
    end
  end

  // eligibility: four exceptions bypass all masks
  always_comb begin
    eligible = '0;
    eligible[EXC_WDOG_TMO-1:0]     = pend[EXC_WDOG_TMO-1:0];
    eligible[EXC_WDOG_TMO]         = pend[EXC_WDOG_TMO] & globEn & wdogEn;
    eligible[NUM_SRC-1:NUM_EXC]    = pend[NUM_SRC-1:NUM_EXC] & enable & {NUM_PERIPH{globEn}};
  end

  // the source being acknowledged is excluded so the next winner is ready
  assign cand = eligible & ~ackMask;

  logic              excFound;
  logic [EIDX_W-1:0] excIdx;

  irqc_find_first #(.W(NUM_EXC)) u_excPick (
    .req  (cand[NUM_EXC-1:0]),
    .found(excFound),
    .idx  (excIdx)
  );

  logic [2:0][NUM_PERIPH-1:0] lvlMask;
  logic [2:0]                 lvlFound;
  logic [2:0][PIDX_W-1:0]     lvlIdx;

  for (genvar g = 0; g < 3; g++) begin : g_level
    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_src
      assign lvlMask[g][i] = cand[NUM_EXC+i] &&
                             (levelOf({lvlHi[i], lvlLo[i]}) == 2'(g + 1));
    end
    irqc_find_first #(.W(NUM_PERIPH)) u_lvlPick (
      .req  (lvlMask[g]),
      .found(lvlFound[g]),
      .idx  (lvlIdx[g])
    );
  end

  always_comb begin
    winFound = 1'b1;
    winIdx   = '0;
    if (excFound)         winIdx = VEC_W'(excIdx);
    else if (lvlFound[2]) winIdx = VEC_W'(NUM_EXC) + VEC_W'(lvlIdx[2]);
    else if (lvlFound[1]) winIdx = VEC_W'(NUM_EXC) + VEC_W'(lvlIdx[1]);
    else if (lvlFound[0]) winIdx = VEC_W'(NUM_EXC) + VEC_W'(lvlIdx[0]);
    else                  winFound = 1'b0;
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      ADDR_PEND_P: rdData = REG_W'(pend[NUM_SRC-1:NUM_EXC]);
      ADDR_PEND_E: rdData = REG_W'(pend[NUM_EXC-1:0]);
      ADDR_ENABLE: rdData = REG_W'(enable);
      ADDR_LVL_LO: rdData = REG_W'(lvlLo);
      ADDR_LVL_HI: rdData = REG_W'(lvlHi);
      ADDR_CTRL:   rdData = REG_W'({wdogEn, globEn});
      default:     rdData = '0;
    endcase
  end

  // ---- checks ----
  logic [(1<<VEC_W)-1:0] winOneHot;
  assign winOneHot = (1 << VEC_W)'(1) << winIdx;

  p_exc_first_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|cand[NUM_EXC-1:0]) |-> (winFound && winIdx < VEC_W'(NUM_EXC)));

  p_level_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!(|cand[NUM_EXC-1:0]) && (|lvlMask[2])) |->
      ((winOneHot[NUM_SRC-1:NUM_EXC] & lvlMask[2]) != '0));

  p_nmi_found_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|(pend[EXC_WDOG_TMO-1:0] & ~ackMask[EXC_WDOG_TMO-1:0])) |-> winFound);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != '0) |=> ((pend & $past(setMask)) == $past(setMask)));

  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && ((ackMask & setMask) == '0)) |=> ((pend & $past(ackMask)) == '0));

endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned VEC_W   = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         regAddr,
  input  logic               regWrEn,
  input  logic               ackIn,
  input  logic [NUM_SRC-1:0] eligible,
  input  logic               winFound,
  input  logic [VEC_W-1:0]   winIdx,
  output ctlStb_t            stb,
  output logic [VEC_W-1:0]   ackIdx,
  output logic               irqOut,
  output logic [VEC_W-1:0]   vecOut
);

  logic [VEC_W-1:0]        vecReg;
  logic                    vecValid;
  logic [(1<<VEC_W)-1:0]   eligPad;
  logic                    curLive;

  assign eligPad = (1 << VEC_W)'(eligible);
  assign curLive = vecValid && eligPad[vecReg];

  always_comb begin
    stb          = '0;
    stb.pendPClr = regWrEn && (regAddr == ADDR_PEND_P);
    stb.pendEClr = regWrEn && (regAddr == ADDR_PEND_E);
    stb.enWr     = regWrEn && (regAddr == ADDR_ENABLE);
    stb.lvlLoWr  = regWrEn && (regAddr == ADDR_LVL_LO);
    stb.lvlHiWr  = regWrEn && (regAddr == ADDR_LVL_HI);
    stb.ctlWr    = regWrEn && (regAddr == ADDR_CTRL);
    stb.ack      = ackIn && curLive;
  end

  // hold the presented vector until it is served or withdrawn
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg   <= '0;
      vecValid <= 1'b0;
    end else if (stb.ack || !curLive) begin
      if (winFound) vecReg <= winIdx;
      vecValid <= winFound;
    end
  end

  assign ackIdx = vecReg;
  assign irqOut = curLive;
  assign vecOut = vecReg;

  // ---- checks ----
  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackIn) |=> (!irqOut || $stable(vecOut)));

  p_vec_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (vecOut < VEC_W'(NUM_SRC)));

endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 8,
  parameter int unsigned REG_W      = 8,
  localparam int unsigned NUM_SRC   = NUM_PERIPH + NUM_EXC,
  localparam int unsigned VEC_W     = $clog2(NUM_SRC)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2:0]            regAddr,
  input  logic                  regWrEn,
  input  logic [REG_W-1:0]      regWrData,
  output logic [REG_W-1:0]      regRdData,
  input  logic [NUM_PERIPH-1:0] periphReq,
  input  logic [NUM_EXC-1:0]    excReq,
  input  logic                  ackIn,
  output logic                  irqOut,
  output logic [VEC_W-1:0]      vecOut
);

  ctlStb_t            stb;
  logic [VEC_W-1:0]   ackIdx;
  logic [NUM_SRC-1:0] eligible;
  logic               winFound;
  logic [VEC_W-1:0]   winIdx;

  irqc_control #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .ackIn   (ackIn),
    .eligible(eligible),
    .winFound(winFound),
    .winIdx  (winIdx),
    .stb     (stb),
    .ackIdx  (ackIdx),
    .irqOut  (irqOut),
    .vecOut  (vecOut)
  );

  irqc_datapath #(
    .NUM_PERIPH(NUM_PERIPH), .REG_W(REG_W), .NUM_SRC(NUM_SRC), .VEC_W(VEC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .regAddr  (regAddr),
    .ackIdx   (ackIdx),
    .periphReq(periphReq),
    .excReq   (excReq),
    .rdData   (regRdData),
    .eligible (eligible),
    .winFound (winFound),
    .winIdx   (winIdx)
  );

endmodule

// File: tb/irqc_top_bench.sv
`timescale 1ns/1ps
module irqc_top_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic [7:0] periphReq;
  logic [4:0] excReq;
  logic       ackIn;
  logic       irqOut;
  logic [3:0] vecOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  irqc_top u_irqc_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .periphReq(periphReq),
    .excReq(excReq), .ackIn(ackIn), .irqOut(irqOut), .vecOut(vecOut)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdData);
  endtask

  task automatic pulseP(logic [7:0] m);
    periphReq = m; step(); periphReq = '0;
  endtask

  task automatic ack();
    ackIn = 1'b1; step(); ackIn = 1'b0;
  endtask

  task automatic cleanup();
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h00);
    step();
  endtask

  task automatic t_reset();
    int v;
    chk("R11", "irq after reset", int'(irqOut), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R11", "register after reset", v, 0);
    end
  endtask

  task automatic t_poll();
    int v;
    wr(3'd5, 8'h01);
    pulseP(8'h08);
    rd(3'd0, v); chk("R3", "pending set by edge", v, 8'h08);
    step();      chk("R6", "disabled source no irq", int'(irqOut), 0);
    wr(3'd0, 8'hFF);
    rd(3'd0, v); chk("R5", "write 1 keeps bit", v, 8'h08);
    wr(3'd0, 8'hF7);
    rd(3'd0, v); chk("R6", "poll and clear", v, 0);
    periphReq = 8'h10; step();
    rd(3'd0, v); chk("R3", "held level sets once", v, 8'h10);
    wr(3'd0, 8'h00); step();
    rd(3'd0, v); chk("R3", "held level no re-set", v, 0);
    periphReq = '0; step();
    pulseP(8'h02);
    ack();
    rd(3'd0, v); chk("R4", "ack with irq low ignored", v, 8'h02);
    cleanup();
  endtask

  task automatic t_levels();
    int v;
    wr(3'd2, 8'hFF); wr(3'd3, 8'h40); wr(3'd4, 8'h42); wr(3'd5, 8'h01);
    pulseP(8'h46); step();
    chk("R10", "irq raised", int'(irqOut), 1);
    chk("R1", "level 3 first", int'(vecOut), 11);
    ack();
    chk("R10", "irq held across ack", int'(irqOut), 1);
    chk("R1", "level 2 next", int'(vecOut), 6);
    rd(3'd0, v); chk("R4", "ack clears only served", v, 8'h06);
    ack();
    chk("R1", "level 1 last", int'(vecOut), 7);
    ack();
    chk("R4", "irq drops when drained", int'(irqOut), 0);
    rd(3'd0, v); chk("R4", "all served", v, 0);
    wr(3'd3, 8'h20); wr(3'd4, 8'h00);
    pulseP(8'h30); step();
    chk("R2", "lower index wins", int'(vecOut), 9);
    ack();
    chk("R2", "higher index next", int'(vecOut), 10);
    ack();
    chk("R2", "irq low after both", int'(irqOut), 0);
    cleanup();
  endtask

  task automatic t_nmi();
    int v;
    wr(3'd2, 8'hFF);
    excReq = 5'b01100; periphReq = 8'h01; step();
    excReq = '0; periphReq = '0; step();
    chk("R7", "nmi with global off", int'(irqOut), 1);
    chk("R7", "illegal before trap", int'(vecOut), 2);
    ack();
    chk("R7", "trap next", int'(vecOut), 3);
    ack();
    chk("R7", "peripheral still masked", int'(irqOut), 0);
    rd(3'd0, v); chk("R6", "masked peripheral pending", v, 8'h01);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h01); wr(3'd4, 8'h01); wr(3'd5, 8'h01);
    excReq = 5'b00001; periphReq = 8'h01; step();
    excReq = '0; periphReq = '0; step();
    chk("R7", "exception over level 3", int'(vecOut), 0);
    ack();
    chk("R7", "peripheral after exception", int'(vecOut), 5);
    ack();
    chk("R7", "irq low after both", int'(irqOut), 0);
    cleanup();
  endtask

  task automatic t_wdog();
    int v;
    excReq = 5'b10000; step(); excReq = '0; step();
    chk("R8", "watchdog masked by default", int'(irqOut), 0);
    rd(3'd1, v); chk("R3", "watchdog pending bit 4", v, 8'h10);
    wr(3'd5, 8'h01); step();
    chk("R8", "global alone not enough", int'(irqOut), 0);
    wr(3'd5, 8'h03); step();
    chk("R8", "both enables raise", int'(irqOut), 1);
    chk("R8", "watchdog vector", int'(vecOut), 4);
    ack();
    rd(3'd1, v); chk("R4", "watchdog served", v, 0);
    cleanup();
  endtask

  task automatic t_setWins();
    int v;
    pulseP(8'h02);
    periphReq = 8'h01; regAddr = 3'd0; regWrData = 8'h00; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0; periphReq = '0;
    rd(3'd0, v); chk("R9", "set beats clear", v, 8'h01);
    cleanup();
  endtask

  task automatic t_hold();
    wr(3'd2, 8'hFF); wr(3'd3, 8'h80); wr(3'd4, 8'h80); wr(3'd5, 8'h01);
    pulseP(8'h08);
    chk("R10", "irq not yet after one edge", int'(irqOut), 0);
    step();
    chk("R10", "irq after two edges", int'(irqOut), 1);
    chk("R10", "level 1 presented", int'(vecOut), 8);
    pulseP(8'h80); step(); step();
    chk("R10", "vector held", int'(vecOut), 8);
    chk("R10", "irq held", int'(irqOut), 1);
    ack();
    chk("R10", "level 3 after ack", int'(vecOut), 12);
    ack();
    chk("R10", "irq low at end", int'(irqOut), 0);
    cleanup();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    periphReq = '0; excReq = '0; ackIn = 1'b0;
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_poll();
    t_levels();
    t_nmi();
    t_wdog();
    t_setWins();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule